// File: doc/BRIEF.md
# Configurable CRC Engine

This block keeps a running cyclic redundancy checksum over data words pushed into it by a processor or a DMA engine. A mode register picks one of three standard generator polynomials at run time. The same register also holds four transform options: two act on each incoming data word before it is folded in, and two act on the checksum as it is presented at the output. A seed register supplies the start value of the checksum.

Writes arrive on a plain register-style interface. A write may load a new mode, a new seed, or a data word of 8, 16 or 32 bits, and a new write can come every cycle with no stall. The checksum output is combinational from the internal state, so reading it never disturbs the calculation. The polynomial division runs most-significant-bit first with no built-in reflection. Reflected standards, such as the common Ethernet-style CRC-32, are formed by enabling the input and output reverse options and the output complement option.

Top module: `crc_engine`

## Requirements
- R1: After reset the mode is 0 (CRC-CCITT, no transforms), the held seed is 0xFFFFFFFF and `sum_o` reads 0x0000FFFF.
- R2: `mode_i[1:0]` selects the polynomial. The value 0 selects 0x1021 (16-bit checksum) and 1 selects 0x8005 (16-bit). The values 2 and 3 select 0x04C11DB7 (32-bit). Each byte is shifted in MSB first with no reflection. For the input "123456789" the results are: 0x29B1 for CRC-CCITT with seed 0xFFFF, 0xFEE8 for CRC-16 with seed 0, and 0x0376E6E7 for CRC-32 with seed 0xFFFFFFFF.
- R3: A seed write stores `seed_i` and, from the next cycle, replaces the checksum with the seed's low W bits, where W is the checksum width.
- R4: A mode write reloads the checksum with the held seed, masked to the new width. If a seed write happens in the same cycle, the new seed is used. A data write in a cycle with a seed or mode write is ignored.
- R5: `data_size_i` gives the write width: 0 is a byte in `data_i[7:0]`, 1 is a halfword in `[15:0]`, and 2 or 3 is a full word. The written bytes are folded in least significant byte first. Data bits above the written width have no effect.
- R6: With `mode[2]` set, the bit order of the written data is reversed across its written width (8, 16 or 32 bits) before it is processed.
- R7: With `mode[3]` set, the written data bits are ones-complemented before they are processed.
- R8: `mode[4]` reverses the checksum's W bits at the output and `mode[5]` complements them. In 16-bit modes, `sum_o[31:16]` is zero.
- R9: Without writes the checksum holds its value. Back-to-back data writes each take effect in the next cycle. With `mode_i` = 0x36, seed 0xFFFFFFFF and byte writes of "123456789", the output is 0xCBF43926.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 6 | Mode: [1:0] polynomial, [2] input reverse, [3] input complement, [4] output reverse, [5] output complement |
| seed_we_i | input | 1 | Seed write strobe |
| seed_i | input | 32 | Seed value |
| data_we_i | input | 1 | Data write strobe |
| data_size_i | input | 2 | Data write width code |
| data_i | input | 32 | Data word |
| sum_o | output | 32 | Checksum with output transforms applied |

## Verification
The catalogue check string "123456789" is fed as single bytes and as mixed word and byte writes. This shows whether the three polynomials and the least-significant-byte-first lane order are correct. Feeding it with the reflect and complement options set reproduces the reflected CRC-32 result, which tests the input and output transforms together. Random mode, seed, width and data writes, with junk in the unused upper bits, are compared after every write against a bench model. These runs separate width masking, reload priority and the transform options from one another. Idle stretches and writes that collide with a load show that reads do not change the state and that data in a load cycle is dropped.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned MODE_W = 6;

  localparam logic [31:0] POLY_CCITT = 32'h0000_1021;
  localparam logic [31:0] POLY_C16   = 32'h0000_8005;
  localparam logic [31:0] POLY_C32   = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    SEL_CCITT = 2'd0,
    SEL_C16   = 2'd1,
    SEL_C32   = 2'd2,
    SEL_C32B  = 2'd3
  } poly_sel_e;

  function automatic logic [CRC_W-1:0] width_mask(input logic [1:0] sel);
    width_mask = sel[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // one byte, MSB first, non-reflected
  function automatic logic [CRC_W-1:0] step_byte(input logic [CRC_W-1:0] c,
                                                 input logic [7:0] b,
                                                 input logic [1:0] sel);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (sel[1]) begin
        fb = r[31] ^ b[k];
        r  = {r[30:0], 1'b0};
        if (fb) r = r ^ POLY_C32;
      end else begin
        fb = r[15] ^ b[k];
        r  = {16'h0, r[14:0], 1'b0};
        if (fb) r = r ^ (sel[0] ? POLY_C16 : POLY_CCITT);
      end
    end
    step_byte = r;
  endfunction
endpackage

// File: rtl/crc_in_xform.sv
module crc_in_xform
  import crc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              rev_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] word_o,
  output logic [3:0]        nbytes_o
);
  logic [DATA_W-1:0] masked, rev8, rev16, rev32, mask;

  always_comb begin
    unique case (size_i)
      2'd0:    begin mask = 32'h0000_00FF; nbytes_o = 4'd1; end
      2'd1:    begin mask = 32'h0000_FFFF; nbytes_o = 4'd2; end
      default: begin mask = 32'hFFFF_FFFF; nbytes_o = 4'(LANES); end
    endcase
  end

  assign masked = data_i & mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev32[i] = masked[DATA_W-1-i];
    if (i < 16) begin : g_h
      assign rev16[i] = masked[15-i];
    end else begin : g_hz
      assign rev16[i] = 1'b0;
    end
    if (i < 8) begin : g_b
      assign rev8[i] = masked[7-i];
    end else begin : g_bz
      assign rev8[i] = 1'b0;
    end
  end

  always_comb begin
    word_o = masked;
    if (rev_i) begin
      unique case (size_i)
        2'd0:    word_o = rev8;
        2'd1:    word_o = rev16;
        default: word_o = rev32;
      endcase
    end
    if (inv_i) word_o = word_o ^ mask;
  end
endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [3:0]        nbytes_i,
  input  logic [1:0]        sel_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [LANES+1];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign stage[i+1] = (4'(i) < nbytes_i)
                        ? step_byte(stage[i], word_i[8*i +: 8], sel_i)
                        : stage[i];
  end

  assign crc_o = stage[LANES];
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic             wide_i,
  input  logic             rev_i,
  input  logic             inv_i,
  output logic [CRC_W-1:0] sum_o
);
  logic [CRC_W-1:0] rev_w, rev_n, mask, v;

  for (genvar i = 0; i < CRC_W; i++) begin : g_rev
    assign rev_w[i] = crc_i[CRC_W-1-i];
    if (i < 16) begin : g_n
      assign rev_n[i] = crc_i[15-i];
    end else begin : g_nz
      assign rev_n[i] = 1'b0;
    end
  end

  assign mask = wide_i ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  always_comb begin
    v = crc_i & mask;
    if (rev_i) v = wide_i ? rev_w : rev_n;
    if (inv_i) v = v ^ mask;
    sum_o = v;
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              seed_we_i,
  input  logic [CRC_W-1:0]  seed_i,
  input  logic              data_we_i,
  input  logic [1:0]        data_size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  sum_o
);
  logic [MODE_W-1:0] mode_q, mode_n;
  logic [CRC_W-1:0]  seed_q, seed_n, crc_q, crc_step;
  logic [DATA_W-1:0] word;
  logic [3:0]        nbytes;
  logic              load;

  assign load   = mode_we_i | seed_we_i;
  assign mode_n = mode_we_i ? mode_i : mode_q;
  assign seed_n = seed_we_i ? seed_i : seed_q;

  crc_in_xform u_in (
    .data_i  (data_i),
    .size_i  (data_size_i),
    .rev_i   (mode_q[2]),
    .inv_i   (mode_q[3]),
    .word_o  (word),
    .nbytes_o(nbytes)
  );

  crc_core u_core (
    .crc_i   (crc_q),
    .word_i  (word),
    .nbytes_i(nbytes),
    .sel_i   (mode_q[1:0]),
    .crc_o   (crc_step)
  );

  crc_out_xform u_out (
    .crc_i (crc_q),
    .wide_i(mode_q[1]),
    .rev_i (mode_q[4]),
    .inv_i (mode_q[5]),
    .sum_o (sum_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      seed_q <= '1;
      crc_q  <= 32'h0000_FFFF;
    end else begin
      mode_q <= mode_n;
      seed_q <= seed_n;
      if (load)           crc_q <= seed_n & width_mask(mode_n[1:0]);
      else if (data_we_i) crc_q <= crc_step;
    end
  end

  assert_seed_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we_i |=> crc_q == ($past(seed_i) & width_mask(mode_q[1:0])));

  assert_mode_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !seed_we_i) |=> crc_q == ($past(seed_q) & width_mask(mode_q[1:0])));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_we_i || seed_we_i || data_we_i) |=> $stable(crc_q) && $stable(sum_o));

  assert_narrow_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[1] |-> sum_o[31:16] == 16'h0);

  assert_narrow_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q[1] && data_we_i && !load) |=> crc_q[31:16] == 16'h0);
endmodule

// File: tb/sim_crc_engine.sv
module sim_crc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0, seed_we = 1'b0, data_we = 1'b0;
  logic [5:0]  mode = '0;
  logic [31:0] seed = '0, data = '0;
  logic [1:0]  dsize = '0;
  logic [31:0] sum;

  int n_cmp = 0, n_bad = 0;
  logic [5:0]  m_mode;
  logic [31:0] m_seed, m_crc;

  always #10 clk = ~clk;

  crc_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .seed_we_i(seed_we), .seed_i(seed), .data_we_i(data_we),
    .data_size_i(dsize), .data_i(data), .sum_o(sum)
  );

  function automatic int wbits(input logic [5:0] md);
    return md[1] ? 32 : 16;
  endfunction

  function automatic logic [31:0] m_poly(input logic [5:0] md);
    case (md[1:0])
      2'd0: return 32'h1021;
      2'd1: return 32'h8005;
      default: return 32'h04C11DB7;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] b,
                                         input logic [5:0] md);
    int w = wbits(md);
    logic [31:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic top = r[w-1] ^ b[k];
      r = (r << 1) & wmask(w);
      if (top) r = r ^ m_poly(md);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_data(input logic [31:0] c, input logic [31:0] d,
                                         input logic [1:0] sz, input logic [5:0] md);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    logic [31:0] v = 0, r = c;
    for (int i = 0; i < nb*8; i++) v[i] = md[2] ? d[nb*8-1-i] : d[i];
    for (int i = 0; i < nb*8; i++) if (md[3]) v[i] = ~v[i];
    for (int i = 0; i < nb; i++) r = m_byte(r, v[8*i +: 8], md);
    return r;
  endfunction

  function automatic logic [31:0] m_out(input logic [31:0] c, input logic [5:0] md);
    int w = wbits(md);
    logic [31:0] v = 0;
    for (int i = 0; i < w; i++) v[i] = md[4] ? c[w-1-i] : c[i];
    if (md[5]) v = v ^ wmask(w);
    return v;
  endfunction

  task automatic check(input logic [31:0] exp, input string req);
    n_cmp++;
    if (sum !== exp) begin
      n_bad++;
      $display("FAIL %s: sum_o=%h expected=%h", req, sum, exp);
    end
  endtask

  // drive at negedge, the register updates at next posedge, sample at following negedge
  task automatic cyc(input logic mw, input logic [5:0] m, input logic sw,
                     input logic [31:0] s, input logic dw, input logic [1:0] sz,
                     input logic [31:0] d);
    mode_we = mw; mode = m; seed_we = sw; seed = s;
    data_we = dw; dsize = sz; data = d;
    if (mw || sw) begin
      if (mw) m_mode = m;
      if (sw) m_seed = s;
      m_crc = m_seed & wmask(wbits(m_mode));
    end else if (dw) m_crc = m_data(m_crc, d, sz, m_mode);
    @(negedge clk);
    mode_we = 0; seed_we = 0; data_we = 0;
  endtask

  task automatic feed_digits();
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 1, 2'd0, 32'hA5A5_A500 | (32'h31 + i));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_mode = 0; m_seed = 32'hFFFF_FFFF; m_crc = 32'hFFFF;
    repeat (2) @(negedge clk);
    check(32'h0000_FFFF, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(32'h0000_FFFF, "R1 after reset release");

    // R2 catalogue values, byte writes with junk above the byte (R5)
    cyc(1, 6'h00, 1, 32'h0000_FFFF, 0, 0, 0);
    feed_digits();
    check(32'h0000_29B1, "R2 CCITT check value");
    cyc(1, 6'h01, 1, 32'h0, 0, 0, 0);
    feed_digits();
    check(32'h0000_FEE8, "R2 CRC-16 check value");
    cyc(1, 6'h02, 1, 32'hFFFF_FFFF, 0, 0, 0);
    feed_digits();
    check(32'h0376_E6E7, "R2 CRC-32 check value");

    // R5 lane order: words and a byte give the same result
    cyc(1, 6'h00, 1, 32'h0000_FFFF, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 2'd2, 32'h3433_3231);
    cyc(0, 0, 0, 0, 1, 2'd3, 32'h3837_3635);
    cyc(0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FF39);
    check(32'h0000_29B1, "R5 word lanes LSB first");

    // R6 R8 R9 reflected CRC-32, back to back
    cyc(1, 6'h36, 1, 32'hFFFF_FFFF, 0, 0, 0);
    feed_digits();
    check(32'hCBF4_3926, "R9 reflected CRC-32 via transforms R6 R8");

    // R9 idle hold
    repeat (5) @(negedge clk);
    check(32'hCBF4_3926, "R9 hold without writes");

    // R4 collision: seed + mode + data same cycle, new seed, data dropped
    cyc(1, 6'h01, 1, 32'h1234_ABCD, 1, 2'd2, 32'hDEAD_BEEF);
    check(32'h0000_ABCD, "R4 new seed wins, data ignored");
    cyc(0, 0, 1, 32'h0000_5555, 1, 2'd0, 32'h77);
    check(32'h0000_5555, "R3 seed write replaces checksum");
    cyc(1, 6'h02, 0, 0, 0, 0, 0);
    check(32'h0000_5555, "R4 mode write reloads held seed");
    cyc(1, 6'h30, 0, 0, 0, 0, 0);
    check(m_out(32'h5555, 6'h30), "R8 narrow output reverse and complement");

    // R7 complement on halfword
    cyc(1, 6'h08, 1, 32'h0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 2'd1, 32'hFFFF_0000);
    check(m_data(32'h0, 32'hFFFF, 2'd1, 6'h00), "R7 input complement");

    // random mix
    void'($urandom(32'd1357));
    for (int it = 0; it < 600; it++) begin
      int pick = $urandom_range(0, 99);
      if (pick < 8)       cyc(1, 6'($urandom()), 0, 0, $urandom_range(0,1) == 1, 2'($urandom()), $urandom());
      else if (pick < 14) cyc(0, 0, 1, $urandom(), 0, 0, 0);
      else if (pick < 18) begin repeat (2) @(negedge clk); end
      else                cyc(0, 0, 0, 0, 1, 2'($urandom()), $urandom());
      check(m_out(m_crc, m_mode), "R2 R5 R6 R7 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule